// File: doc/BRIEF.md
# Interval-Based Adaptive Buffer Allocator

This controller shares a small pool of line buffers among three cache-assist mechanisms: a victim store (mechanism 0), a stride prefetcher (mechanism 1) and a write buffer (mechanism 2). Each mechanism reports two things every cycle: a miss pulse and a stall pulse. For each mechanism the block counts these pulses over an observation window of programmable length. When the window closes, the block uses the totals to give one buffer to the mechanism that stalled most. It also adjusts how far ahead the prefetcher runs. The counters then clear and the next window begins.

Software reaches the block through a plain register port, with no handshake. A write strobe with an address and data sets the window length or forces the prefetch lookahead. A combinational read port returns the window length, the lookahead, the live counters, the ownership map and a short history of recent receivers. There is no streaming data path, so every pin is a plain control or status signal. The assist mechanisms read the ownership map and the lookahead value and act on them. That part is outside this block.

Top module: `adaptive_buf_alloc`

## Requirements
- R1: After reset, buffer i belongs to mechanism (i*3)/8, so buffers 0-2 go to mechanism 0, 3-5 to mechanism 1 and 6-7 to mechanism 2. Buffer i's owner sits at `own_map[2i+1:2i]`. The lookahead is 2, the window length reads 64 and all counters read 0.
- R2: A write to register address 0 does four things: it sets the window length L, restarts the window and clears every counter, and makes no reallocation decision. The decision is then applied on the L-th rising edge after the write edge. It includes the events sampled on that edge.
- R3: The miss count of mechanism m reads at address 2+m and its stall count at address 5+m. Each counts the sampled pulses of the current window. Both read 0 again after a restart.
- R4: At a window end, the receiver is the mechanism with the highest stall total; on a tie the lowest index wins. The donor is the mechanism with the lowest stall total; on a tie the lowest index wins. The donor's highest-numbered buffer passes to the receiver. No buffer moves when the highest and lowest totals are equal.
- R5: No buffer moves when the donor owns only one buffer, so every mechanism always keeps at least one.
- R6: Prefetch pressure is a sampled cycle with both `pf_full` and the mechanism-1 stall pulse high. If any such cycle occurred in the window, the lookahead rises by one at the window end, saturating at 4.
- R7: If there was no pressure and mechanism 1 recorded no stall in the window, the lookahead falls by one, saturating at 1. Otherwise it holds.
- R8: A write to address 1 sets the lookahead to the written value clamped to 1..4. If it lands on a window-end edge, it overrides the adjustment from R6 and R7, while the buffer move of that edge still takes place.
- R9: The 6-bit receiver history at address 9 shifts left by two bits on each buffer move and takes the receiver index into bits [1:0]. It does not change when no buffer moves.
- R10: Address 8 reads the same value as the `own_map` output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_evt | input | 3 | Per-mechanism miss pulse, one per cycle |
| stall_evt | input | 3 | Per-mechanism stall pulse, one per cycle |
| pf_full | input | 1 | Prefetch buffers are all occupied |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register write address |
| cfg_wdata | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| own_map | output | 16 | 2-bit owner field per buffer |
| lookahead | output | 3 | Prefetch lookahead depth, 1..4 |

## Verification
Two functions can fall in the same cycle: the window-end decision and a software write. The bench aims a lookahead write exactly at the window-end edge while prefetch pressure would otherwise raise the lookahead. It then checks that the clamped software value wins and that the buffer move of the same edge still appears in the map. It also restarts the window partway through, with events already counted, and checks that the map is untouched and the counters read zero. Exact window timing is judged by holding back the only stall pulse until the final sampled cycle.

// File: rtl/abal_pkg.sv
package abal_pkg;
  localparam int ADDR_W       = 4;
  localparam int REG_W        = 16;
  localparam int REG_INTERVAL = 0;
  localparam int REG_LOOKAHD  = 1;
  localparam int REG_MISS0    = 2;
  localparam int REG_STALL0   = 5;
  localparam int REG_OWNMAP   = 8;
  localparam int REG_HIST     = 9;
  localparam int PF_IDX       = 1;
endpackage

// File: rtl/abal_interval_timer.sv
module abal_interval_timer #(
  parameter int CW    = 16,
  parameter int T_RST = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          len_we,
  input  logic [CW-1:0] len_wdata,
  output logic [CW-1:0] interval_len,
  output logic          boundary
);
  logic [CW-1:0] tick;

  // lengths 0 and 1 both close the window every cycle
  assign boundary = !len_we &&
                    (({1'b0, tick} + (CW+1)'(1)) >= {1'b0, interval_len});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      interval_len <= CW'(T_RST);
      tick         <= '0;
    end else if (len_we) begin
      interval_len <= len_wdata;
      tick         <= '0;
    end else if (boundary) begin
      tick <= '0;
    end else begin
      tick <= tick + CW'(1);
    end
  end
endmodule

// File: rtl/abal_mech_counters.sv
module abal_mech_counters #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          miss_in,
  input  logic          stall_in,
  output logic [CW-1:0] miss_cnt,
  output logic [CW-1:0] stall_cnt,
  output logic [CW-1:0] stall_nxt
);
  logic [CW-1:0] miss_nxt;

  // saturating increments
  assign miss_nxt  = (miss_in  && miss_cnt  != '1) ? miss_cnt  + CW'(1) : miss_cnt;
  assign stall_nxt = (stall_in && stall_cnt != '1) ? stall_cnt + CW'(1) : stall_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miss_cnt  <= '0;
      stall_cnt <= '0;
    end else if (clear) begin
      miss_cnt  <= '0;
      stall_cnt <= '0;
    end else begin
      miss_cnt  <= miss_nxt;
      stall_cnt <= stall_nxt;
    end
  end
endmodule

// File: rtl/abal_realloc.sv
module abal_realloc #(
  parameter int N_BUF  = 8,
  parameter int N_MECH = 3,
  parameter int CW     = 16,
  localparam int OWN_W  = $clog2(N_MECH),
  localparam int IDX_W  = $clog2(N_BUF),
  localparam int CNT_W  = $clog2(N_BUF + 1),
  localparam int HIST_W = 3 * OWN_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    boundary,
  input  logic [N_MECH*CW-1:0]    stall_flat,
  output logic [N_BUF*OWN_W-1:0]  own_map,
  output logic [HIST_W-1:0]       hist
);
  logic [OWN_W-1:0] own_q [N_BUF];
  logic [CW-1:0]    st    [N_MECH];
  logic [OWN_W-1:0] hi, lo;
  logic [IDX_W-1:0] vb;
  logic [CNT_W-1:0] lo_cnt;
  logic             do_move;

  for (genvar m = 0; m < N_MECH; m++) begin : g_st
    assign st[m] = stall_flat[m*CW +: CW];
  end
  for (genvar b = 0; b < N_BUF; b++) begin : g_map
    assign own_map[b*OWN_W +: OWN_W] = own_q[b];
  end

  always_comb begin
    hi = '0;
    lo = '0;
    for (int m = 1; m < N_MECH; m++) begin
      if (st[m] > st[hi]) hi = OWN_W'(m);
      if (st[m] < st[lo]) lo = OWN_W'(m);
    end
    lo_cnt = '0;
    vb     = '0;
    for (int b = 0; b < N_BUF; b++) begin
      if (own_q[b] == lo) begin
        lo_cnt = lo_cnt + CNT_W'(1);
        vb     = IDX_W'(b);
      end
    end
    do_move = boundary && (st[hi] != st[lo]) && (lo_cnt > CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < N_BUF; b++) own_q[b] <= OWN_W'((b * N_MECH) / N_BUF);
      hist <= '0;
    end else if (do_move) begin
      own_q[vb] <= hi;
      hist      <= {hist[HIST_W-OWN_W-1:0], hi};
    end
  end
endmodule

// File: rtl/abal_lookahead.sv
module abal_lookahead #(
  parameter int LA_MIN = 1,
  parameter int LA_MAX = 4,
  parameter int LA_RST = 2,
  parameter int DW     = 16,
  localparam int LA_W  = $clog2(LA_MAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            boundary,
  input  logic            restart,
  input  logic            pf_full,
  input  logic            pf_stall,
  input  logic            pf_stall_nz,
  input  logic            sw_we,
  input  logic [DW-1:0]   sw_data,
  output logic [LA_W-1:0] la
);
  logic            press_q, press_nxt;
  logic [LA_W-1:0] sw_clamp;

  assign press_nxt = press_q || (pf_full && pf_stall);

  always_comb begin
    if (sw_data < DW'(LA_MIN))      sw_clamp = LA_W'(LA_MIN);
    else if (sw_data > DW'(LA_MAX)) sw_clamp = LA_W'(LA_MAX);
    else                            sw_clamp = sw_data[LA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      press_q <= 1'b0;
      la      <= LA_W'(LA_RST);
    end else begin
      press_q <= (boundary || restart) ? 1'b0 : press_nxt;
      if (sw_we) begin
        la <= sw_clamp;
      end else if (boundary) begin
        if (press_nxt) begin
          if (la < LA_W'(LA_MAX)) la <= la + LA_W'(1);
        end else if (!pf_stall_nz) begin
          if (la > LA_W'(LA_MIN)) la <= la - LA_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/adaptive_buf_alloc.sv
module adaptive_buf_alloc
  import abal_pkg::*;
#(
  parameter int N_BUF  = 8,
  parameter int N_MECH = 3,
  parameter int CW     = 16,
  parameter int T_RST  = 64,
  parameter int LA_MIN = 1,
  parameter int LA_MAX = 4,
  parameter int LA_RST = 2,
  localparam int OWN_W = $clog2(N_MECH),
  localparam int LA_W  = $clog2(LA_MAX + 1),
  localparam int MAP_W = N_BUF * OWN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_MECH-1:0] miss_evt,
  input  logic [N_MECH-1:0] stall_evt,
  input  logic              pf_full,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic [MAP_W-1:0]  own_map,
  output logic [LA_W-1:0]   lookahead
);
  localparam int HIST_W = 3 * OWN_W;

  logic                 len_we, la_we, boundary, clear;
  logic [CW-1:0]        interval_len;
  logic [CW-1:0]        miss_cnt  [N_MECH];
  logic [CW-1:0]        stall_cnt [N_MECH];
  logic [N_MECH*CW-1:0] stall_nxt_flat;
  logic [HIST_W-1:0]    hist;

  assign len_we = cfg_we && (cfg_addr == ADDR_W'(REG_INTERVAL));
  assign la_we  = cfg_we && (cfg_addr == ADDR_W'(REG_LOOKAHD));
  assign clear  = boundary || len_we;

  abal_interval_timer #(.CW(CW), .T_RST(T_RST)) timer_i (
    .clk(clk), .rst_n(rst_n), .len_we(len_we), .len_wdata(CW'(cfg_wdata)),
    .interval_len(interval_len), .boundary(boundary)
  );

  for (genvar m = 0; m < N_MECH; m++) begin : g_mech
    abal_mech_counters #(.CW(CW)) cnt_i (
      .clk(clk), .rst_n(rst_n), .clear(clear),
      .miss_in(miss_evt[m]), .stall_in(stall_evt[m]),
      .miss_cnt(miss_cnt[m]), .stall_cnt(stall_cnt[m]),
      .stall_nxt(stall_nxt_flat[m*CW +: CW])
    );
  end

  abal_realloc #(.N_BUF(N_BUF), .N_MECH(N_MECH), .CW(CW)) realloc_i (
    .clk(clk), .rst_n(rst_n), .boundary(boundary),
    .stall_flat(stall_nxt_flat), .own_map(own_map), .hist(hist)
  );

  abal_lookahead #(.LA_MIN(LA_MIN), .LA_MAX(LA_MAX), .LA_RST(LA_RST), .DW(REG_W)) la_i (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .restart(len_we),
    .pf_full(pf_full), .pf_stall(stall_evt[PF_IDX]),
    .pf_stall_nz(stall_nxt_flat[PF_IDX*CW +: CW] != '0),
    .sw_we(la_we), .sw_data(cfg_wdata), .la(lookahead)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_W'(REG_INTERVAL): rd_data = REG_W'(interval_len);
      ADDR_W'(REG_LOOKAHD):  rd_data = REG_W'(lookahead);
      ADDR_W'(REG_OWNMAP):   rd_data = REG_W'(own_map);
      ADDR_W'(REG_HIST):     rd_data = REG_W'(hist);
      default: begin
        for (int m = 0; m < N_MECH; m++) begin
          if (rd_addr == ADDR_W'(REG_MISS0 + m))  rd_data = REG_W'(miss_cnt[m]);
          if (rd_addr == ADDR_W'(REG_STALL0 + m)) rd_data = REG_W'(stall_cnt[m]);
        end
      end
    endcase
  end
endmodule

// File: rtl/abal_chk.sv
module abal_chk #(
  parameter int N_BUF  = 8,
  parameter int N_MECH = 3,
  parameter int OWN_W  = 2,
  parameter int LA_W   = 3,
  parameter int LA_MIN = 1,
  parameter int LA_MAX = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [N_BUF*OWN_W-1:0] own_map,
  input logic [LA_W-1:0]        lookahead,
  input logic                   cfg_we,
  input logic [3:0]             cfg_addr,
  input logic                   boundary
);
  logic [N_BUF*OWN_W-1:0] prev_map;
  logic                   prev_ok;
  logic [N_BUF-1:0]       diff;
  logic                   legal, min_ok;
  logic                   la_wr;

  assign la_wr = cfg_we && (cfg_addr == 4'd1);

  always_comb begin
    legal  = 1'b1;
    min_ok = 1'b1;
    for (int b = 0; b < N_BUF; b++) begin
      if (int'(own_map[b*OWN_W +: OWN_W]) >= N_MECH) legal = 1'b0;
      diff[b] = own_map[b*OWN_W +: OWN_W] != prev_map[b*OWN_W +: OWN_W];
    end
    for (int m = 0; m < N_MECH; m++) begin
      int c;
      c = 0;
      for (int b = 0; b < N_BUF; b++)
        if (int'(own_map[b*OWN_W +: OWN_W]) == m) c++;
      if (c == 0) min_ok = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_map <= '0;
      prev_ok  <= 1'b0;
    end else begin
      prev_map <= own_map;
      prev_ok  <= 1'b1;
    end
  end

  a_r1_owner_legal: assert property (@(posedge clk) disable iff (!rst_n) legal);
  a_r5_min_one: assert property (@(posedge clk) disable iff (!rst_n) min_ok);
  a_r4_single_move: assert property (@(posedge clk) disable iff (!rst_n)
    prev_ok |-> ($countones(diff) <= 1));
  a_r2_hold_mid_window: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(own_map));
  a_r6_la_range: assert property (@(posedge clk) disable iff (!rst_n)
    (lookahead >= LA_W'(LA_MIN)) && (lookahead <= LA_W'(LA_MAX)));
  a_r7_la_step: assert property (@(posedge clk) disable iff (!rst_n)
    !la_wr |=> (({1'b0, $past(lookahead)} <= {1'b0, lookahead} + 1'b1) &&
                ({1'b0, lookahead} <= {1'b0, $past(lookahead)} + 1'b1)));
endmodule

bind adaptive_buf_alloc abal_chk #(
  .N_BUF(N_BUF), .N_MECH(N_MECH), .OWN_W(OWN_W), .LA_W(LA_W),
  .LA_MIN(LA_MIN), .LA_MAX(LA_MAX)
) chk_i (
  .clk(clk), .rst_n(rst_n), .own_map(own_map), .lookahead(lookahead),
  .cfg_we(cfg_we), .cfg_addr(cfg_addr), .boundary(boundary)
);

// File: tb/adaptive_buf_alloc_tb_top.sv
`timescale 1ns/1ps
module adaptive_buf_alloc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  miss_evt = '0, stall_evt = '0;
  logic        pf_full = 1'b0, cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0, rd_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] rd_data, own_map;
  logic [2:0]  lookahead;

  int n_chk = 0, n_fail = 0;
  int own_m [8];
  int la_m, hist_m;

  always #4 clk = ~clk;

  adaptive_buf_alloc dut_i (
    .clk(clk), .rst_n(rst_n), .miss_evt(miss_evt), .stall_evt(stall_evt),
    .pf_full(pf_full), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data), .own_map(own_map), .lookahead(lookahead)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int map_m();
    int v = 0;
    for (int b = 0; b < 8; b++) v |= own_m[b] << (2*b);
    return v;
  endfunction

  task automatic read_reg(input int a, output int v);
    rd_addr = 4'(a);
    #1;
    v = int'(rd_data);
  endtask

  // expected effect of one window end
  task automatic model_end(input int s0, input int s1, input int s2,
                           input bit press, input bit sw, input int swv);
    int st [3];
    int hi = 0, lo = 0, cnt = 0, vb = 0;
    st[0] = s0; st[1] = s1; st[2] = s2;
    for (int m = 1; m < 3; m++) begin
      if (st[m] > st[hi]) hi = m;
      if (st[m] < st[lo]) lo = m;
    end
    for (int b = 0; b < 8; b++) if (own_m[b] == lo) begin cnt++; vb = b; end
    if (st[hi] != st[lo] && cnt > 1) begin
      own_m[vb] = hi;
      hist_m = ((hist_m << 2) | hi) & 63;
    end
    if (sw)                  la_m = (swv < 1) ? 1 : (swv > 4) ? 4 : swv;
    else if (press && s1 > 0) la_m = (la_m < 4) ? la_m + 1 : 4;
    else if (s1 == 0)        la_m = (la_m > 1) ? la_m - 1 : 1;
  endtask

  task automatic check_state(input string tag);
    int v;
    check(own_map == 16'(map_m()), {tag, " R4 R5 own_map"}, int'(own_map), map_m());
    check(lookahead == 3'(la_m), {tag, " R6 R7 R8 lookahead"}, int'(lookahead), la_m);
    read_reg(9, v);
    check(v == hist_m, {tag, " R9 history"}, v, hist_m);
  endtask

  task automatic restart(input int len);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'd0; cfg_wdata = 16'(len);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one full window; stall pulse of mechanism m held for s_m cycles
  task automatic run_window(input int len, input int s0, input int s1, input int s2,
                            input bit press, input bit sw, input int swv);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'd0; cfg_wdata = 16'(len);
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      cfg_we    = 1'b0;
      stall_evt = {c < s2, c < s1, c < s0};
      miss_evt  = {1'b0, c < s1, 1'b0};
      pf_full   = press && (c == 0);
      if (sw && c == len - 1) begin
        cfg_we = 1'b1; cfg_addr = 4'd1; cfg_wdata = 16'(swv);
      end
    end
    @(negedge clk);
    cfg_we = 1'b0; stall_evt = '0; miss_evt = '0; pf_full = 1'b0;
    model_end(s0, s1, s2, press, sw, swv);
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    int v;
    for (int b = 0; b < 8; b++) own_m[b] = (b * 3) / 8;
    la_m = 2; hist_m = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R10 map register
    check(own_map == 16'(map_m()), "R1 reset own_map", int'(own_map), map_m());
    check(lookahead == 3'd2, "R1 reset lookahead", int'(lookahead), 2);
    read_reg(0, v); check(v == 64, "R1 reset window length", v, 64);
    for (int a = 2; a < 8; a++) begin
      read_reg(a, v); check(v == 0, "R1 reset counter", v, 0);
    end
    read_reg(8, v); check(v == map_m(), "R10 map register", v, map_m());

    // R3 counters mid-window, R2 restart clears without deciding
    restart(40);
    for (int c = 0; c < 5; c++) begin
      miss_evt  = {1'b0, c < 2, 1'b1};
      stall_evt = {c < 3, 1'b0, 1'b0};
      @(negedge clk);
    end
    miss_evt = '0; stall_evt = '0;
    read_reg(2, v); check(v == 5, "R3 miss count mech0", v, 5);
    read_reg(3, v); check(v == 2, "R3 miss count mech1", v, 2);
    read_reg(7, v); check(v == 3, "R3 stall count mech2", v, 3);
    read_reg(5, v); check(v == 0, "R3 stall count mech0", v, 0);
    restart(40);
    read_reg(7, v); check(v == 0, "R2 restart clears counter", v, 0);
    read_reg(2, v); check(v == 0, "R3 cleared miss count", v, 0);
    check(own_map == 16'(map_m()), "R2 restart makes no move", int'(own_map), map_m());

    // R2 exact timing: only stall pulse on the final sampled cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'd0; cfg_wdata = 16'd6;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      cfg_we = 1'b0;
      if (c == 5) begin
        check(own_map == 16'(map_m()), "R2 no move before window end",
              int'(own_map), map_m());
        stall_evt = 3'b010;
      end
    end
    @(negedge clk);
    stall_evt = '0;
    model_end(0, 1, 0, 1'b0, 1'b0, 0);
    check_state("R2 last-cycle event");

    // R4 R5 R7 R9 sweep of stall totals
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++) begin
          run_window(8, a, b, c, 1'b0, 1'b0, 0);
          check_state("sweep");
        end

    // R6 pressure raises lookahead up to saturation
    for (int k = 0; k < 5; k++) begin
      run_window(8, 0, 2, 1, 1'b1, 1'b0, 0);
      check_state("R6 pressure");
    end

    // R8 software write on the window-end edge overrides pressure
    run_window(8, 1, 3, 0, 1'b1, 1'b1, 0);
    check_state("R8 write at window end");
    run_window(8, 0, 2, 3, 1'b0, 1'b1, 9);
    check_state("R8 write clamp high");

    // R8 standalone clamps
    restart(8);
    cfg_we = 1'b1; cfg_addr = 4'd1; cfg_wdata = 16'd0;
    @(negedge clk);
    cfg_we = 1'b0;
    check(lookahead == 3'd1, "R8 clamp low", int'(lookahead), 1);
    cfg_we = 1'b1; cfg_addr = 4'd1; cfg_wdata = 16'd3;
    @(negedge clk);
    cfg_we = 1'b0;
    check(lookahead == 3'd3, "R8 in-range write", int'(lookahead), 3);
    read_reg(1, v); check(v == 3, "R8 lookahead register", v, 3);
    read_reg(8, v); check(v == int'(own_map), "R10 map register", v, int'(own_map));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule